// File: doc/BRIEF.md
# FIFO Flag Offset Register Port

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. The empty offset and the full offset are reached through the FIFO's ordinary data buses rather than through a register map. While the active-low offset select `ld_n` is held low, a write strobe stores the low bits of the write data bus into one offset register. A read strobe returns one offset register on the read data bus.

Each side keeps its own selection pointer. The write pointer moves only on offset writes (write clock) and the read pointer moves only on offset readbacks (read clock). Both pointers start at the empty offset, step to the full offset, and then wrap back. After reset, both offsets hold a default that depends on the FIFO depth. While offset access is selected, the enables toward the FIFO storage array are held off. The block flags an offset read and an offset write that fall in the same period.

Top module: `ofs_port_top`

## Requirements
- R1: After reset, `empty_ofs` and `full_ofs` both equal the depth default (31 for DEPTH ≤ 256, 63 for DEPTH ≤ 512, otherwise 127), `rd_data` is zero, and both pointers select the empty offset.
- R2: With `ld_n`=0 and `wr_en_n`=0, each write-clock edge stores `wr_data[OFS_W-1:0]` into the register the write pointer selects and advances that pointer in the order empty, full, empty, and so on.
- R3: With `ld_n`=0 and `wr_en_n`=1, a write-clock edge changes neither offset and does not move the write pointer.
- R4: With `ld_n`=0 and `rd_en_n`=0, each read-clock edge loads `rd_data` with the register the read pointer selects, then advances that pointer in the order empty, full, empty, and so on.
- R5: Offset reads never move the write pointer, and offset writes never move the read pointer.
- R6: Only the low OFS_W = log2(DEPTH) bits of `wr_data` are stored. Readback fills `rd_data` bits above OFS_W-1 with zeros.
- R7: `ofs_collide` is 1 exactly when an offset write and an offset read are both requested in the same cycle. In that cycle the write takes effect and the readback returns the value held before the write.
- R8: `arr_wr_en` = !`wr_en_n` & `ld_n` and `arr_rd_en` = !`rd_en_n` & `ld_n`, so the storage array is never enabled while `ld_n` is 0.
- R9: While `ld_n`=1, no strobe changes either offset or either pointer.
- R10: `rd_data` keeps its value on every read-clock edge that is not an offset readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low offset access select |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | Write data bus |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DATA_W | Offset readback data |
| empty_ofs | output | OFS_W | Empty offset to flag logic |
| full_ofs | output | OFS_W | Full offset to flag logic |
| arr_wr_en | output | 1 | Storage array write enable |
| arr_rd_en | output | 1 | Storage array read enable |
| ofs_collide | output | 1 | Same-period offset read and write |

## Verification
The hardest situation to reach is one where the two pointers are out of step. For example, the write pointer sits on the full offset while the read pointer sits on the empty offset, and both strobes then land in one cycle. The stimulus first advances only the write pointer with a single write. It then issues a combined read and write, so that the readback must return the register that the write is not touching, and this is checked against the pre-write value. A long random phase with biased enables repeats such mismatched pointer states many times.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;

  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

  function automatic int default_offset(input int depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    else return 127;
  endfunction
endpackage

// File: rtl/ofs_gate.sv
module ofs_gate (
  input  logic ld_n,
  input  logic wr_en_n,
  input  logic rd_en_n,
  output logic wr_evt,
  output logic rd_evt,
  output logic arr_wr_en,
  output logic arr_rd_en,
  output logic collide
);
  always_comb begin
    wr_evt    = !ld_n && !wr_en_n;
    rd_evt    = !ld_n && !rd_en_n;
    arr_wr_en = ld_n && !wr_en_n;
    arr_rd_en = ld_n && !rd_en_n;
    collide   = wr_evt && rd_evt;
  end
endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 10,
  parameter int DATA_W = 18,
  parameter int DEF    = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output ofs_sel_e          ptr
);
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF);

  logic [OFS_W-1:0] wr_val;
  assign wr_val = wr_data[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_ofs <= DEF_V;
      full_ofs  <= DEF_V;
      ptr       <= SEL_EMPTY;
    end else if (wr_evt) begin
      if (ptr == SEL_EMPTY) empty_ofs <= wr_val;
      else                  full_ofs  <= wr_val;
      ptr <= next_sel(ptr);
    end
  end
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_data,
  output ofs_sel_e          ptr
);
  logic [OFS_W-1:0]  sel_val;
  logic [DATA_W-1:0] sel_ext;

  assign sel_val = (ptr == SEL_EMPTY) ? empty_ofs : full_ofs;

  generate
    if (DATA_W > OFS_W) begin : g_pad
      assign sel_ext = {{(DATA_W-OFS_W){1'b0}}, sel_val};
    end else begin : g_exact
      assign sel_ext = sel_val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ptr     <= SEL_EMPTY;
    end else if (rd_evt) begin
      rd_data <= sel_ext;
      ptr     <= next_sel(ptr);
    end
  end
endmodule

// File: rtl/ofs_port_top.sv
module ofs_port_top
  import ofs_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 18,
  parameter int OFS_W  = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              arr_wr_en,
  output logic              arr_rd_en,
  output logic              ofs_collide
);
  localparam int DEF = default_offset(DEPTH);

  logic     wr_evt;
  logic     rd_evt;
  ofs_sel_e wr_ptr;
  ofs_sel_e rd_ptr;

  ofs_gate gate_i (
    .ld_n      (ld_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .wr_evt    (wr_evt),
    .rd_evt    (rd_evt),
    .arr_wr_en (arr_wr_en),
    .arr_rd_en (arr_rd_en),
    .collide   (ofs_collide)
  );

  ofs_wr_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W), .DEF(DEF)) bank_i (
    .clk       (wr_clk),
    .rst_n     (rst_n),
    .wr_evt    (wr_evt),
    .wr_data   (wr_data),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .ptr       (wr_ptr)
  );

  ofs_rd_port #(.OFS_W(OFS_W), .DATA_W(DATA_W)) rdp_i (
    .clk       (rd_clk),
    .rst_n     (rst_n),
    .rd_evt    (rd_evt),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rd_data   (rd_data),
    .ptr       (rd_ptr)
  );
endmodule

// File: rtl/ofs_port_chk.sv
module ofs_port_chk #(
  parameter int OFS_W  = 10,
  parameter int DATA_W = 18
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              ld_n,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic              wr_ptr,
  input logic              rd_ptr,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic [DATA_W-1:0] rd_data,
  input logic              arr_wr_en,
  input logic              arr_rd_en,
  input logic              collide
);
  // R2
  wr_ptr_adv_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_evt |=> wr_ptr != $past(wr_ptr));

  // R3
  wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!ld_n && wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wr_ptr)));

  // R4
  rd_ptr_adv_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_evt |=> rd_ptr != $past(rd_ptr));

  // R5
  ptr_indep_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (rd_evt && !wr_evt) |=> $stable(wr_ptr));

  // R6
  rd_upper_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_data >> OFS_W) == '0);

  // R7
  collide_src_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    collide |-> (!ld_n && !wr_en_n && !rd_en_n));

  // R8
  arr_block_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !ld_n |-> (!arr_wr_en && !arr_rd_en));

  // R9
  sel_off_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ld_n |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wr_ptr)));

  // R10
  rd_keep_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rd_data));
endmodule

bind ofs_port_top ofs_port_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) chk_i (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .rst_n     (rst_n),
  .ld_n      (ld_n),
  .wr_en_n   (wr_en_n),
  .rd_en_n   (rd_en_n),
  .wr_evt    (wr_evt),
  .rd_evt    (rd_evt),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .rd_data   (rd_data),
  .arr_wr_en (arr_wr_en),
  .arr_rd_en (arr_rd_en),
  .collide   (ofs_collide)
);

// File: tb/ofs_port_top_tb_top.sv
module ofs_port_top_tb_top;
  localparam int DEPTH  = 1024;
  localparam int DATA_W = 18;
  localparam int OFS_W  = 10;
  localparam int DEFV   = 127;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              ld_n, wr_en_n, rd_en_n;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;
  logic              arr_wr_en, arr_rd_en, ofs_collide;

  ofs_port_top #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .ld_n(ld_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .arr_wr_en(arr_wr_en), .arr_rd_en(arr_rd_en), .ofs_collide(ofs_collide)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  int m_empty, m_full, m_rd;
  int m_wsel, m_rsel;   // 0 = empty offset, 1 = full offset

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " empty_ofs"}, int'(empty_ofs), m_empty);
    chk({tag, " full_ofs"},  int'(full_ofs),  m_full);
    chk({tag, " rd_data"},   int'(rd_data),   m_rd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ld_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_empty = DEFV; m_full = DEFV; m_rd = 0; m_wsel = 0; m_rsel = 0;
    @(negedge clk);
    check_regs("R1 reset");
  endtask

  // one cycle: drive at negedge, check comb outputs, model the edge, compare
  task automatic step(input string tag, input bit ld, input bit wen, input bit ren,
                      input int data);
    bit we, re;
    int rv;
    ld_n = ld; wr_en_n = wen; rd_en_n = ren; wr_data = DATA_W'(data);
    #1;
    we = !ld && !wen;
    re = !ld && !ren;
    chk("R8 arr_wr_en", int'(arr_wr_en), int'(ld && !wen));
    chk("R8 arr_rd_en", int'(arr_rd_en), int'(ld && !ren));
    chk("R7 ofs_collide", int'(ofs_collide), int'(we && re));
    @(posedge clk);
    rv = (m_rsel == 0) ? m_empty : m_full;
    if (re) begin m_rd = rv; m_rsel = 1 - m_rsel; end
    if (we) begin
      if (m_wsel == 0) m_empty = data % DEPTH; else m_full = data % DEPTH;
      m_wsel = 1 - m_wsel;
    end
    @(negedge clk);
    check_regs(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 load order and wrap
    step("R2 write empty", 0, 0, 1, 5);
    step("R2 write full",  0, 0, 1, 900);
    step("R2 wrap empty",  0, 0, 1, 17);
    // R3 enable high ignored (write pointer now on full)
    step("R3 ignored", 0, 1, 1, 333);
    step("R3 ignored", 0, 1, 1, 444);
    step("R3 next write lands full", 0, 0, 1, 250);
    // R9 select off: array access, no offset change
    step("R9 ld high write", 1, 0, 1, 77);
    step("R9 ld high read",  1, 1, 0, 78);
    step("R9 ld high both",  1, 0, 0, 79);
    // R4 readback order and wrap
    step("R4 read empty", 0, 1, 0, 0);
    step("R4 read full",  0, 1, 0, 0);
    step("R4 read wrap",  0, 1, 0, 0);
    // R10 hold
    step("R10 hold", 0, 1, 1, 0);
    step("R10 hold", 1, 1, 1, 0);
    // R5 independence: read pointer on full, write pointer on empty
    step("R5 write only", 0, 0, 1, 600);
    step("R5 read only",  0, 1, 0, 0);
    step("R5 read only",  0, 1, 0, 0);
    // R6 upper bits dropped
    step("R6 wide write", 0, 0, 1, 32'h3_FC0A);
    step("R6 wide write", 0, 0, 1, 32'h2_AAAA);
    step("R6 readback", 0, 1, 0, 0);
    step("R6 readback", 0, 1, 0, 0);
    // R7 collision with pointers out of step
    step("R7 advance write ptr", 0, 0, 1, 11);
    step("R7 collide", 0, 0, 0, 99);
    step("R7 collide", 0, 0, 0, 123);
    // R1 reset mid-run
    do_reset();
    step("R1 read after reset", 0, 1, 0, 0);
    // random phase
    for (int i = 0; i < 400; i++) begin
      step("R2 R4 random", ($urandom % 4) == 0, ($urandom % 3) == 0,
           ($urandom % 3) == 0, int'($urandom % (1 << DATA_W)));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule